// File: doc/BRIEF.md
# Slave Host Interface Buffer

This block is the slave end of an 8-bit asynchronous master/slave port. An external host reaches three registers through a chip select, a read strobe, a write strobe and an address line A0. The three registers are a byte written by the host (inbound), a byte read by the host (outbound) and an 8-bit status byte. The internal side loads the outbound byte, takes the inbound byte, writes the four user bits of the status byte and sets flag F0. It also enables two optional pin functions: interrupt flag pins and a DMA request/acknowledge handshake.

The host strobes are sampled on the block clock. Every flag change caused by the host takes effect at the clock edge that sees the strobe return high. While the host is reading status, changes to status from the internal side are held back and applied when that read ends. The four upper pins of the port behave as plain latched outputs until the internal side switches them to flag or DMA use.

Top module: `hostif_buffer`

## Requirements
- R1: A host read with A0=1 returns the status byte, laid out as {user[3:0], F1, F0, IBF, OBF} from bit 7 down to bit 0. A host read with A0=0 returns the outbound byte.
- R2: A user-status write copies its 4-bit value into status bits 7:4 and leaves bits 3:0 unchanged.
- R3: A host write stores the data byte in the inbound register, sets IBF and copies A0 into F1 (1 = command, 0 = data). An internal read of the inbound register clears IBF.
- R4: An internal load sets OBF and stores the outbound byte. A host data read (A0=0) clears OBF.
- R5: IBF, OBF and F1 change only on the clock edge that first samples the strobe high again after it was low, never while the strobe is low.
- R6: While the host reads status (chip select low, read low, A0=1), internal loads, inbound reads, user-status writes and F0 writes leave the status byte unchanged. They take effect on the edge that ends the read.
- R7: host_doe is high only while the read strobe is low and either chip select is low or an acknowledge is active. It is low at all other times.
- R8: After flag mode is enabled, pin_p24 equals port latch bit 0 AND OBF, and pin_p25 equals port latch bit 1 AND NOT IBF.
- R9: After DMA mode is enabled, pin_p26 shows the request. A port write with bit 2 = 1 raises the request. An active acknowledge together with either strobe low drops it, and so does a repeated DMA enable. A drop wins over a raise in the same cycle.
- R10: In DMA mode, an active-low acknowledge selects the data registers: A0 is treated as 0, so reads return the outbound byte and clear OBF, and writes clear F1.
- R11: After reset the status byte is 0, the port latches are 1111, pin_p24..pin_p27 follow the latches, pin_p27_oe is 1, and the acknowledge input is ignored until DMA mode is enabled. Once DMA mode is on, pin_p27_oe is 0.
- R12: When a host clear and an internal set of the same flag fall in the same cycle, the set wins. A host write ending together with an inbound read leaves IBF=1. A host data read ending together with a load leaves OBF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host register select: 1 = status/command, 0 = data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Host data bus drive enable |
| int_load_out | input | 1 | Internal pulse: load the outbound byte |
| int_out_data | input | 8 | Byte for the outbound register |
| int_read_in | input | 1 | Internal pulse: inbound byte consumed |
| int_in_data | output | 8 | Inbound register contents |
| int_sts_we | input | 1 | Internal pulse: write the user status bits |
| int_acc_hi | input | 4 | Value for status bits 7:4 |
| int_f0_we | input | 1 | Internal pulse: write F0 |
| int_f0_val | input | 1 | Value for F0 |
| int_flags_en | input | 1 | Internal pulse: switch pins 24/25 to flag use |
| int_dma_en | input | 1 | Internal pulse: switch pins 26/27 to DMA use |
| int_port_we | input | 1 | Internal pulse: write the upper port latches |
| int_port_data | input | 4 | Latch values for pins 24..27 |
| int_status | output | 8 | Status byte as seen internally |
| dma_dack_n | input | 1 | DMA acknowledge, active low |
| pin_p24 | output | 1 | Port pin 24 / OBF flag |
| pin_p25 | output | 1 | Port pin 25 / inverted IBF flag |
| pin_p26 | output | 1 | Port pin 26 / DMA request |
| pin_p27 | output | 1 | Port pin 27 latch value |
| pin_p27_oe | output | 1 | Drive enable for pin 27 (0 while it is the acknowledge input) |

## Verification
The assertions rely on the host inputs being synchronous to the block clock and on the read and write strobes never being low together. They also rely on a status read never overlapping an active acknowledge. The bench meets these conditions: it drives every input just after the falling clock edge. It opens one access at a time, with chip select and A0 set a cycle before the strobe and released a cycle after it. It asserts the acknowledge only with chip select high and only in the DMA section. Same-cycle conflicts between internal operations and host strobes are placed only on the cycle that ends a strobe.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NIB_W   = BYTE_W / 2;
    localparam int unsigned DRQ_BIT = 2;

    typedef struct packed {
        logic              obf;
        logic              ibf;
        logic              f0;
        logic              f1;
        logic [NIB_W-1:0]  usr;
        logic [BYTE_W-1:0] out_reg;
        logic [BYTE_W-1:0] in_reg;
        logic              pend_ld;
        logic [BYTE_W-1:0] pend_data;
        logic              pend_rdin;
        logic              pend_sts;
        logic [NIB_W-1:0]  pend_usr;
        logic              pend_f0;
        logic              pend_f0v;
        logic              flag_mode;
        logic              dma_mode;
        logic              drq;
        logic [NIB_W-1:0]  port_lat;
    } hif_state_t;
endpackage

// File: rtl/hostif_strobe.sv
module hostif_strobe
    import hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [BYTE_W-1:0] din,
    input  logic              dack_act,
    output logic              sel_now,
    output logic              a0_eff,
    output logic              status_rd,
    output logic              rd_end,
    output logic              wr_end,
    output logic              cap_sel,
    output logic              cap_a0,
    output logic [BYTE_W-1:0] cap_data
);
    logic rd_low_q, wr_low_q;

    assign sel_now   = ~cs_n | dack_act;
    assign a0_eff    = a0 & ~dack_act;
    assign status_rd = ~rd_n & ~cs_n & a0 & ~dack_act;
    assign rd_end    = rd_low_q & rd_n;
    assign wr_end    = wr_low_q & wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_low_q <= 1'b0;
            wr_low_q <= 1'b0;
            cap_sel  <= 1'b0;
            cap_a0   <= 1'b0;
            cap_data <= '0;
        end else begin
            rd_low_q <= ~rd_n;
            wr_low_q <= ~wr_n;
            if (~rd_n | ~wr_n) begin
                cap_sel  <= sel_now;
                cap_a0   <= a0_eff;
                cap_data <= din;
            end
        end
    end
endmodule

// File: rtl/hostif_pins.sv
module hostif_pins
    import hostif_pkg::*;
(
    input  logic             flag_mode,
    input  logic             dma_mode,
    input  logic             obf,
    input  logic             ibf,
    input  logic             drq,
    input  logic [NIB_W-1:0] port_lat,
    output logic             p24,
    output logic             p25,
    output logic             p26,
    output logic             p27,
    output logic             p27_oe
);
    always_comb begin
        p24    = flag_mode ? (port_lat[0] & obf)  : port_lat[0];
        p25    = flag_mode ? (port_lat[1] & ~ibf) : port_lat[1];
        p26    = dma_mode  ? drq                  : port_lat[2];
        p27    = port_lat[3];
        p27_oe = ~dma_mode;
    end
endmodule

// File: rtl/hostif_buffer.sv
module hostif_buffer
    import hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              int_load_out,
    input  logic [BYTE_W-1:0] int_out_data,
    input  logic              int_read_in,
    output logic [BYTE_W-1:0] int_in_data,
    input  logic              int_sts_we,
    input  logic [NIB_W-1:0]  int_acc_hi,
    input  logic              int_f0_we,
    input  logic              int_f0_val,
    input  logic              int_flags_en,
    input  logic              int_dma_en,
    input  logic              int_port_we,
    input  logic [NIB_W-1:0]  int_port_data,
    output logic [BYTE_W-1:0] int_status,
    input  logic              dma_dack_n,
    output logic              pin_p24,
    output logic              pin_p25,
    output logic              pin_p26,
    output logic              pin_p27,
    output logic              pin_p27_oe
);
    hif_state_t st_q, st_d;

    logic              dack_act, sel_now, a0_eff, status_rd;
    logic              rd_end, wr_end, cap_sel, cap_a0;
    logic [BYTE_W-1:0] cap_data;

    assign dack_act = st_q.dma_mode & ~dma_dack_n;

    hostif_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (host_cs_n),
        .rd_n      (host_rd_n),
        .wr_n      (host_wr_n),
        .a0        (host_a0),
        .din       (host_din),
        .dack_act  (dack_act),
        .sel_now   (sel_now),
        .a0_eff    (a0_eff),
        .status_rd (status_rd),
        .rd_end    (rd_end),
        .wr_end    (wr_end),
        .cap_sel   (cap_sel),
        .cap_a0    (cap_a0),
        .cap_data  (cap_data)
    );

    assign int_status  = {st_q.usr, st_q.f1, st_q.f0, st_q.ibf, st_q.obf};
    assign int_in_data = st_q.in_reg;
    assign host_doe    = ~host_rd_n & sel_now;
    assign host_dout   = a0_eff ? int_status : st_q.out_reg;

    always_comb begin
        st_d = st_q;
        // host data read completes: outbound byte consumed
        if (rd_end && cap_sel && !cap_a0) st_d.obf = 1'b0;
        if (status_rd) begin
            if (int_load_out) begin
                st_d.pend_ld   = 1'b1;
                st_d.pend_data = int_out_data;
            end
            if (int_read_in) st_d.pend_rdin = 1'b1;
            if (int_sts_we) begin
                st_d.pend_sts = 1'b1;
                st_d.pend_usr = int_acc_hi;
            end
            if (int_f0_we) begin
                st_d.pend_f0  = 1'b1;
                st_d.pend_f0v = int_f0_val;
            end
        end else begin
            st_d.pend_ld   = 1'b0;
            st_d.pend_rdin = 1'b0;
            st_d.pend_sts  = 1'b0;
            st_d.pend_f0   = 1'b0;
            if (int_read_in || st_q.pend_rdin) st_d.ibf = 1'b0;
            if (int_load_out || st_q.pend_ld) begin
                st_d.out_reg = int_load_out ? int_out_data : st_q.pend_data;
                st_d.obf     = 1'b1;
            end
            if (int_sts_we || st_q.pend_sts)
                st_d.usr = int_sts_we ? int_acc_hi : st_q.pend_usr;
            if (int_f0_we || st_q.pend_f0)
                st_d.f0 = int_f0_we ? int_f0_val : st_q.pend_f0v;
        end
        // host write completes: set after any internal clear
        if (wr_end && cap_sel) begin
            st_d.in_reg = cap_data;
            st_d.f1     = cap_a0;
            st_d.ibf    = 1'b1;
        end
        if (int_port_we) begin
            st_d.port_lat = int_port_data;
            if (st_q.dma_mode && int_port_data[DRQ_BIT]) st_d.drq = 1'b1;
        end
        if (int_dma_en) begin
            st_d.dma_mode = 1'b1;
            st_d.drq      = 1'b0;
        end
        if (dack_act && (!host_rd_n || !host_wr_n)) st_d.drq = 1'b0;
        if (int_flags_en) st_d.flag_mode = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.port_lat <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    hostif_pins u_pins (
        .flag_mode (st_q.flag_mode),
        .dma_mode  (st_q.dma_mode),
        .obf       (st_q.obf),
        .ibf       (st_q.ibf),
        .drq       (st_q.drq),
        .port_lat  (st_q.port_lat),
        .p24       (pin_p24),
        .p25       (pin_p25),
        .p26       (pin_p26),
        .p27       (pin_p27),
        .p27_oe    (pin_p27_oe)
    );
endmodule

// File: rtl/hostif_buffer_chk.sv
module hostif_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs_n,
    input logic       host_rd_n,
    input logic       host_wr_n,
    input logic       host_a0,
    input logic       dma_dack_n,
    input logic       host_doe,
    input logic [7:0] int_status
);
    // R7: bus released whenever the read strobe is high
    a_r7_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_n |-> !host_doe);

    // R5: IBF rises only on the edge that ends a write strobe
    a_r5_ibf_on_wr_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[1]) |-> ($past(host_wr_n) && !$past(host_wr_n, 2)));

    // R4: OBF falls only on the edge that ends a read strobe
    a_r4_obf_on_rd_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[0]) |-> ($past(host_rd_n) && !$past(host_rd_n, 2)));

    // R6: status frozen across a cycle in which the host reads it
    a_r6_status_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!host_rd_n && !host_cs_n && host_a0 && dma_dack_n) |-> $stable(int_status));
endmodule

bind hostif_buffer hostif_buffer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs_n  (host_cs_n),
    .host_rd_n  (host_rd_n),
    .host_wr_n  (host_wr_n),
    .host_a0    (host_a0),
    .dma_dack_n (dma_dack_n),
    .host_doe   (host_doe),
    .int_status (int_status)
);

// File: tb/hostif_buffer_tb.sv
module hostif_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0;
    logic       ld = 1'b0, rdin = 1'b0, stswe = 1'b0, f0we = 1'b0, f0v = 1'b0;
    logic [7:0] odata = '0;
    logic [3:0] acc = '0, pdata = '0;
    logic       flen = 1'b0, dmaen = 1'b0, pwe = 1'b0, dack_n = 1'b1;
    logic [7:0] dout, indata, status;
    logic       doe, p24, p25, p26, p27, p27oe;

    int compared = 0, mismatched = 0;
    bit checking = 0;

    // behavioural model state
    bit       m_obf, m_ibf, m_f0, m_f1, m_flag, m_dma, m_drq;
    bit [3:0] m_usr, m_lat;
    bit [7:0] m_out, m_in, m_cd;
    bit       m_rdl, m_wrl, m_csel, m_ca0;
    int       pq[$];

    always #10 clk = ~clk;

    hostif_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_a0(a0), .host_din(din), .host_dout(dout), .host_doe(doe),
        .int_load_out(ld), .int_out_data(odata), .int_read_in(rdin), .int_in_data(indata),
        .int_sts_we(stswe), .int_acc_hi(acc), .int_f0_we(f0we), .int_f0_val(f0v),
        .int_flags_en(flen), .int_dma_en(dmaen), .int_port_we(pwe), .int_port_data(pdata),
        .int_status(status), .dma_dack_n(dack_n), .pin_p24(p24), .pin_p25(p25),
        .pin_p26(p26), .pin_p27(p27), .pin_p27_oe(p27oe)
    );

    function automatic bit [7:0] mstat();
        return {m_usr, m_f1, m_f0, m_ibf, m_obf};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_apply(input int op);
        int kind = op / 256;
        bit [7:0] v = 8'(op % 256);
        case (kind)
            0: m_ibf = 0;
            1: begin m_out = v; m_obf = 1; end
            2: m_usr = v[3:0];
            default: m_f0 = v[0];
        endcase
    endtask

    task automatic model_reset();
        m_obf = 0; m_ibf = 0; m_f0 = 0; m_f1 = 0; m_flag = 0; m_dma = 0; m_drq = 0;
        m_usr = 0; m_lat = 4'hF; m_out = 0; m_in = 0; m_cd = 0;
        m_rdl = 0; m_wrl = 0; m_csel = 0; m_ca0 = 0; pq.delete();
    endtask

    task automatic model_step();
        bit dk, sel, a0e, rd_end, wr_end, lock, dclr;
        int cur[$];
        if (!rst_n) begin model_reset(); return; end
        dk = m_dma && !dack_n;
        sel = !cs_n || dk;
        a0e = dk ? 1'b0 : a0;
        rd_end = m_rdl && rd_n;
        wr_end = m_wrl && wr_n;
        lock = !rd_n && !cs_n && a0 && !dk;
        dclr = dk && (!rd_n || !wr_n);
        if (rd_end && m_csel && !m_ca0) m_obf = 0;
        if (rdin)  cur.push_back(0);
        if (ld)    cur.push_back(256 + int'(odata));
        if (stswe) cur.push_back(512 + int'(acc));
        if (f0we)  cur.push_back(768 + int'(f0v));
        if (lock) begin
            foreach (cur[i]) pq.push_back(cur[i]);
        end else begin
            while (pq.size() > 0) model_apply(pq.pop_front());
            foreach (cur[i]) model_apply(cur[i]);
        end
        if (wr_end && m_csel) begin m_in = m_cd; m_f1 = m_ca0; m_ibf = 1; end
        if (pwe) begin
            if (m_dma && pdata[2]) m_drq = 1;
            m_lat = pdata;
        end
        if (dmaen) begin m_dma = 1; m_drq = 0; end
        if (dclr) m_drq = 0;
        if (flen) m_flag = 1;
        m_rdl = !rd_n; m_wrl = !wr_n;
        if (!rd_n || !wr_n) begin m_csel = sel; m_ca0 = a0e; m_cd = din; end
    endtask

    task automatic compare();
        bit dk = m_dma && !dack_n;
        bit e_doe = !rd_n && (!cs_n || dk);
        chk("R7 doe", {7'b0, doe}, {7'b0, e_doe});
        if (e_doe) chk(dk ? "R10 dout" : "R1 dout", dout, (a0 && !dk) ? mstat() : m_out);
        chk("R5 status", status, mstat());
        chk("R3 in_data", indata, m_in);
        chk("R8 p24", {7'b0, p24}, {7'b0, m_flag ? (m_lat[0] & m_obf) : m_lat[0]});
        chk("R8 p25", {7'b0, p25}, {7'b0, m_flag ? (m_lat[1] & ~m_ibf) : m_lat[1]});
        chk("R9 p26", {7'b0, p26}, {7'b0, m_dma ? m_drq : m_lat[2]});
        chk("R11 p27", {6'b0, p27, p27oe}, {6'b0, m_lat[3], ~m_dma});
    endtask

    task automatic tick();
        #2;
        if (checking) compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic int_op(input int kind, input logic [7:0] v);
        case (kind)
            0: rdin = 1;
            1: begin ld = 1; odata = v; end
            2: begin stswe = 1; acc = v[3:0]; end
            3: begin f0we = 1; f0v = v[0]; end
            4: begin pwe = 1; pdata = v[3:0]; end
            5: flen = 1;
            default: dmaen = 1;
        endcase
        tick();
        rdin = 0; ld = 0; stswe = 0; f0we = 0; pwe = 0; flen = 0; dmaen = 0;
    endtask

    // end_op: 0 none, 1 inbound read, 2 load on the strobe-ending cycle
    task automatic host_acc(input bit is_rd, input bit a0v, input logic [7:0] d,
                            input bit use_dack, input int end_op);
        logic [7:0] pre;
        cs_n = use_dack; dack_n = !use_dack; a0 = a0v; din = d;
        tick();
        pre = status;
        if (is_rd) rd_n = 0; else wr_n = 0;
        tick(); tick();
        chk("R5 no change while strobe low", status, pre);
        rd_n = 1; wr_n = 1;
        if (end_op == 1) rdin = 1;
        if (end_op == 2) begin ld = 1; odata = 8'hC3; end
        tick();
        rdin = 0; ld = 0;
        cs_n = 1; dack_n = 1;
        tick();
    endtask

    initial begin
        model_reset();
        repeat (3) tick();
        rst_n = 1;
        checking = 1;
        tick();
        // R11 reset state
        chk("R11 reset status", status, 8'h00);
        chk("R11 reset pins", {3'b0, p24, p25, p26, p27, p27oe}, 8'h1F);
        // R1 / R4
        int_op(1, 8'h5A);
        chk("R4 load sets OBF", status, 8'h01);
        host_acc(1, 1, 8'h00, 0, 0);
        host_acc(1, 0, 8'h00, 0, 0);
        chk("R4 data read clears OBF", status, 8'h00);
        // R3
        host_acc(0, 1, 8'h3C, 0, 0);
        chk("R3 command write", status, 8'h0A);
        chk("R3 inbound byte", indata, 8'h3C);
        int_op(0, 0);
        chk("R3 inbound read clears IBF", status, 8'h08);
        host_acc(0, 0, 8'h11, 0, 0);
        chk("R3 data write clears F1", status, 8'h02);
        int_op(0, 0);
        // R2
        int_op(2, 8'h0A);
        chk("R2 user nibble", status, 8'hA0);
        int_op(3, 8'h01);
        chk("R2 F0 kept low nibble", status, 8'hA4);
        // R6 lockout
        cs_n = 0; a0 = 1; tick();
        rd_n = 0; tick();
        int_op(1, 8'h77);
        int_op(2, 8'h05);
        tick();
        chk("R6 held during status read", status, 8'hA4);
        rd_n = 1; tick();
        cs_n = 1; tick();
        chk("R6 applied after read", status, 8'h55);
        // R12
        host_acc(0, 0, 8'h99, 0, 1);
        chk("R12 IBF set wins", status, 8'h57);
        int_op(0, 0);
        host_acc(1, 0, 8'h00, 0, 2);
        chk("R12 OBF set wins", status, 8'h55);
        host_acc(1, 0, 8'h00, 0, 0);
        chk("R4 OBF cleared", status, 8'h54);
        // R8 flag pins
        int_op(5, 0);
        chk("R8 flag pins idle", {6'b0, p24, p25}, 8'h01);
        int_op(1, 8'h21);
        chk("R8 p24 follows OBF", {7'b0, p24}, 8'h01);
        host_acc(0, 0, 8'h44, 0, 0);
        chk("R8 p25 inverse IBF", {7'b0, p25}, 8'h00);
        int_op(4, 8'h0E);
        chk("R8 p24 forced low", {7'b0, p24}, 8'h00);
        int_op(0, 0);
        host_acc(1, 0, 8'h00, 0, 0);
        // R11 acknowledge ignored before DMA mode
        dack_n = 0; rd_n = 0; tick();
        chk("R11 ack ignored", {7'b0, doe}, 8'h00);
        rd_n = 1; tick(); dack_n = 1; tick();
        // mixed traffic
        for (int i = 0; i < 150; i++) begin
            int r = int'($urandom % 7);
            logic [7:0] v = 8'($urandom);
            case (r)
                0: host_acc(0, v[0], v, 0, 0);
                1: host_acc(1, v[1], 8'h00, 0, 0);
                2: int_op(1, v);
                3: int_op(0, 0);
                4: int_op(2, v);
                5: int_op(3, v);
                default: int_op(4, v);
            endcase
        end
        // R9 / R10 DMA handshake
        int_op(6, 0);
        chk("R11 ack pin released", {7'b0, p27oe}, 8'h00);
        int_op(4, 8'h07);
        chk("R9 request raised", {7'b0, p26}, 8'h01);
        int_op(1, 8'hE1);
        host_acc(1, 1, 8'h00, 1, 0);
        chk("R9 request dropped by ack read", {7'b0, p26}, 8'h00);
        chk("R10 ack read clears OBF", {7'b0, status[0]}, 8'h00);
        int_op(4, 8'h07);
        chk("R9 raised again", {7'b0, p26}, 8'h01);
        int_op(6, 0);
        chk("R9 dropped by re-enable", {7'b0, p26}, 8'h00);
        host_acc(0, 1, 8'h42, 1, 0);
        chk("R10 ack write data", indata, 8'h42);
        chk("R10 ack write clears F1", {7'b0, status[3]}, 8'h00);
        repeat (4) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule